// File: doc/BRIEF.md
# Three-Input Vote Up/Down Counter

This block is a two-bit synchronous counter built as a small Moore state machine. Three single-bit control lines are sampled on every rising clock edge. The number of those lines that sit at 0 selects what happens to the count:

- With exactly one line at 0, the count steps up.
- With exactly two lines at 0, the count steps down.
- With all three lines at the same level, either all low or all high, the count is loaded with the value 2, whatever it held before.

The block drives the present count and an odd flag. Both outputs come only from the registered state.

The machine has four states, one per count value: `ST_ZERO`, `ST_ONE`, `ST_TWO` and `ST_THREE`. A classifier turns the three control lines into one of three named commands: `CMD_UP`, `CMD_DOWN` and `CMD_PRESET`. Each state therefore has three named transitions:

- **Step up** follows the ring ZERO→ONE→TWO→THREE→ZERO.
- **Step down** follows the ring ZERO→THREE→TWO→ONE→ZERO.
- **Preset** goes from any state to `ST_TWO`.

A synchronous active-high reset returns the machine to `ST_ZERO`.

Top module: `tri_vote_counter`

## Requirements
- R1: When exactly one of `ctl_a`, `ctl_b`, `ctl_c` is 0 at a rising edge, `count_q` becomes the old count plus one after that edge.
- R2: When exactly two of the three control inputs are 0 at a rising edge, `count_q` becomes the old count minus one after that edge.
- R3: When the three control inputs are all 0 or all 1 at a rising edge, `count_q` becomes 2 after that edge, from any prior count.
- R4: Stepping up from count 3 wraps the count to 0.
- R5: Stepping down from count 0 wraps the count to 3.
- R6: `odd_flag` is 1 exactly when `count_q` is 1 or 3, and 0 when it is 0 or 2.
- R7: When `rst` is high at a rising edge, `count_q` becomes 0 and `odd_flag` becomes 0 after that edge, regardless of the control inputs.
- R8: Between clock edges the outputs depend only on the stored count: changing the control inputs does not change `count_q` or `odd_flag` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to count 0 |
| ctl_a | input | 1 | First control line |
| ctl_b | input | 1 | Second control line |
| ctl_c | input | 1 | Third control line |
| count_q | output | 2 | Present count, 0 to 3 |
| odd_flag | output | 1 | High when the present count is odd |

## Verification
The clocked properties compare each count against the count and control lines of the previous edge. They take for granted that the control lines are stable and known at every rising edge. They also assume that an edge which is not in reset follows another edge that was not in reset.

A one-cycle history flag holds the properties off for the first edge after reset. The bench changes the control lines only a short time after each rising edge. It moves between states only through reset and the step-up command, so every sampled edge carries defined levels.

The sweep then applies all eight control patterns from each of the four states, so every named transition is exercised.

// File: rtl/tvc_pkg.sv
package tvc_pkg;

    localparam int CNT_W      = 2;
    localparam int CTL_N      = 3;
    localparam int ZERO_W     = $clog2(CTL_N + 1);
    localparam logic [CNT_W-1:0] PRESET_VAL = 2'd2;

    typedef enum logic [CNT_W-1:0] {
        ST_ZERO  = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2,
        ST_THREE = 2'd3
    } state_t;

    typedef enum logic [1:0] {
        CMD_UP     = 2'd0,
        CMD_DOWN   = 2'd1,
        CMD_PRESET = 2'd2
    } cmd_t;

endpackage

// File: rtl/tvc_classify.sv
module tvc_classify
    import tvc_pkg::*;
(
    input  logic [CTL_N-1:0] ctl,
    output cmd_t             cmd
);

    logic [ZERO_W-1:0] zero_cnt;

    always_comb begin
        zero_cnt = '0;
        for (int i = 0; i < CTL_N; i++) begin
            zero_cnt = zero_cnt + {{(ZERO_W-1){1'b0}}, !ctl[i]};
        end
    end

    always_comb begin
        if (zero_cnt == ZERO_W'(1)) begin
            cmd = CMD_UP;
        end else if (zero_cnt == ZERO_W'(2)) begin
            cmd = CMD_DOWN;
        end else begin
            cmd = CMD_PRESET;
        end
    end

endmodule

// File: rtl/tvc_fsm.sv
module tvc_fsm
    import tvc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cmd_t   cmd,
    output state_t state
);

    state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ZERO;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ZERO: begin
                unique case (cmd)
                    CMD_UP:     nxt = ST_ONE;
                    CMD_DOWN:   nxt = ST_THREE;
                    default:    nxt = ST_TWO;
                endcase
            end
            ST_ONE: begin
                unique case (cmd)
                    CMD_UP:     nxt = ST_TWO;
                    CMD_DOWN:   nxt = ST_ZERO;
                    default:    nxt = ST_TWO;
                endcase
            end
            ST_TWO: begin
                unique case (cmd)
                    CMD_UP:     nxt = ST_THREE;
                    CMD_DOWN:   nxt = ST_ONE;
                    default:    nxt = ST_TWO;
                endcase
            end
            ST_THREE: begin
                unique case (cmd)
                    CMD_UP:     nxt = ST_ZERO;
                    CMD_DOWN:   nxt = ST_TWO;
                    default:    nxt = ST_TWO;
                endcase
            end
            default: nxt = ST_ZERO;
        endcase
    end

    // History flag: high when the previous edge was a non-reset edge.
    logic hist_ok;
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_ok <= 1'b0;
        end else begin
            hist_ok <= 1'b1;
        end
    end

    a_r4_wrap_up: assert property (@(posedge clk) disable iff (rst)
        hist_ok && $past(state == ST_THREE && cmd == CMD_UP) |-> state == ST_ZERO);

    a_r5_wrap_down: assert property (@(posedge clk) disable iff (rst)
        hist_ok && $past(state == ST_ZERO && cmd == CMD_DOWN) |-> state == ST_THREE);

endmodule

// File: rtl/tvc_outdec.sv
module tvc_outdec
    import tvc_pkg::*;
(
    input  state_t           state,
    output logic [CNT_W-1:0] count,
    output logic             odd
);

    always_comb begin
        unique case (state)
            ST_ZERO:  begin count = 2'd0; odd = 1'b0; end
            ST_ONE:   begin count = 2'd1; odd = 1'b1; end
            ST_TWO:   begin count = 2'd2; odd = 1'b0; end
            ST_THREE: begin count = 2'd3; odd = 1'b1; end
            default:  begin count = 2'd0; odd = 1'b0; end
        endcase
    end

endmodule

// File: rtl/tri_vote_counter.sv
module tri_vote_counter
    import tvc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_a,
    input  logic             ctl_b,
    input  logic             ctl_c,
    output logic [CNT_W-1:0] count_q,
    output logic             odd_flag
);

    logic [CTL_N-1:0] ctl_bus;
    cmd_t             cmd;
    state_t           state;

    assign ctl_bus = {ctl_c, ctl_b, ctl_a};

    tvc_classify u_classify (
        .ctl (ctl_bus),
        .cmd (cmd)
    );

    tvc_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .state (state)
    );

    tvc_outdec u_outdec (
        .state (state),
        .count (count_q),
        .odd   (odd_flag)
    );

    logic rst_d;
    logic run_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            run_d <= 1'b0;
        end else begin
            run_d <= 1'b1;
        end
    end

    a_r1_step_up: assert property (@(posedge clk) disable iff (rst)
        run_d && $past($countones(ctl_bus) == 2) |-> count_q == 2'($past(count_q) + 2'd1));

    a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
        run_d && $past($countones(ctl_bus) == 1) |-> count_q == 2'($past(count_q) - 2'd1));

    a_r3_preset_two: assert property (@(posedge clk) disable iff (rst)
        run_d && $past(ctl_bus == 3'b000 || ctl_bus == 3'b111) |-> count_q == PRESET_VAL);

    a_r6_odd_flag: assert property (@(posedge clk) disable iff (rst)
        odd_flag == (count_q == 2'd1 || count_q == 2'd3));

    a_r7_reset_zero: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (count_q == 2'd0 && !odd_flag));

endmodule

// File: tb/tri_vote_counter_test.sv
module tri_vote_counter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_a = 1'b0;
    logic       ctl_b = 1'b0;
    logic       ctl_c = 1'b0;
    logic [1:0] count_q;
    logic       odd_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tri_vote_counter uut (
        .clk      (clk),
        .rst      (rst),
        .ctl_a    (ctl_a),
        .ctl_b    (ctl_b),
        .ctl_c    (ctl_c),
        .count_q  (count_q),
        .odd_flag (odd_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic [2:0] v);
        {ctl_c, ctl_b, ctl_a} = v;
    endtask

    initial begin
        // R7: reset with a preset pattern present still lands at zero
        rst = 1'b1;
        drive(3'b111);
        tick();
        chk("R7 reset count", int'(count_q), 0);
        chk("R7 reset odd", int'(odd_flag), 0);

        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 8; c++) begin
                rst = 1'b1;
                drive(3'b000);
                tick();
                rst = 1'b0;
                for (int k = 0; k < s; k++) begin
                    drive(3'b011);
                    tick();
                end
                drive(3'(c));
                #1;
                // R8: new inputs do not move outputs before the edge
                chk("R8 count held", int'(count_q), s);
                chk("R8 odd held", int'(odd_flag), s % 2);
                tick();
                begin
                    int zeros;
                    int exp;
                    string tag;
                    zeros = 3 - ((c & 1) + ((c >> 1) & 1) + ((c >> 2) & 1));
                    if (zeros == 1) begin
                        exp = (s + 1) % 4;
                        tag = (s == 3) ? "R4 wrap up" : "R1 step up";
                    end else if (zeros == 2) begin
                        exp = (s + 3) % 4;
                        tag = (s == 0) ? "R5 wrap down" : "R2 step down";
                    end else begin
                        exp = 2;
                        tag = "R3 preset";
                    end
                    chk(tag, int'(count_q), exp);
                    chk("R6 odd flag", int'(odd_flag), exp % 2);
                end
            end
        end

        // R7: reset from a nonzero state overrides an up command
        rst = 1'b0;
        drive(3'b000);
        tick();
        rst = 1'b1;
        drive(3'b110);
        tick();
        chk("R7 reset from two", int'(count_q), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule